// File: doc/BRIEF.md
# Video-synchronized timer channel

A single timer channel with a 16-bit count, a control word and a compare target, all reachable over a small register bus. Left alone it counts enables from a base clock-enable input. Its control word can also bind it to the video raster: counting can be suspended while a blank strobe is high, or restarted from zero at the start of each blank. It can also be stopped outright. An interrupt request pulse is raised when the count reaches the target, when it wraps past its top value, or both.

One module covers three channel flavours through the `VARIANT` parameter. Variant 0 follows horizontal blank and can count pixel-clock enables. Variant 1 follows vertical blank and can count horizontal-blank enables. Variant 2 has no blank coupling and can only be stopped. Producing the clock enables and blank strobes and collecting the interrupt lie outside the block.

Top module: `vsync_timer`

## Requirements
- R1: After reset the count, control and target read as zero and `irq` is low.
- R2: With the sync bit clear, the count advances by one on each cycle where the selected clock enable is high, and wraps from 0xFFFF to 0.
- R3: The register addresses are count = 0, control = 1 and target = 2; address 3 reads zero. A count write loads bits 15:0 of `bus_wdata` and drops the upper bits. A control write stores bits 15:0 and clears the count to zero. Reads return 16-bit values.
- R4: When control bit 3 is set, a step taken while the count equals the target sets the count to 0 instead of adding one.
- R5: A step from count == target raises `irq` if control bit 4 is set. A step from 0xFFFF raises `irq` if control bit 5 is set. `irq` is a one-cycle pulse that is high in the cycle after the step, together with the updated count.
- R6: After one pulse, no further pulse is raised until the control register is written again.
- R7: In variants 0 and 1, control bit 8 makes the count advance on `tick_alt` instead of `tick_base`. Variant 2 always counts `tick_base`.
- R8: In variants 0 and 1, control[2:0] = 1 suspends counting in every cycle where the channel's blank is high. The blank is `hblank` for variant 0 and `vblank` for variant 1.
- R9: In variants 0 and 1, control[2:0] = 3 or 5 clears the count to zero in the cycle where the channel's blank rises. In all other cycles the count advances normally, including while blank is high. The clear produces no interrupt.
- R10: In variants 0 and 1, control[2:0] = 7 counts as if sync were off.
- R11: In variant 2, control[2:0] = 1 or 7 holds the count. Any other value counts freely.
- R12: A bus write takes priority over counting and over blank clears in the same cycle. No step, event or interrupt comes from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write register select |
| bus_wdata | input | 32 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data (combinational) |
| tick_base | input | 1 | Base clock enable |
| tick_alt | input | 1 | Alternate clock enable (pixel or line, per variant) |
| hblank | input | 1 | Horizontal blank level |
| vblank | input | 1 | Vertical blank level |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench builds three instances at the default 16-bit width: `VARIANT` 0, 1 and 2. All three share the same bus, enables and blank strobes. This shows the same control value meaning pause, clear or halt depending on the variant. Preloading the count close to 0xFFFF brings the wrap and overflow interrupt within a few cycles. Blank strobes with short periods exercise pauses and rising-edge clears many times within each phase.

// File: rtl/vsync_timer_pkg.sv
package vsync_timer_pkg;
  localparam int VAR_LINE  = 0;
  localparam int VAR_FRAME = 1;
  localparam int VAR_PLAIN = 2;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_CTRL   = 2'd1,
    REG_TARGET = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  localparam int B_SYNC     = 0;
  localparam int B_TGT_CLR  = 3;
  localparam int B_IRQ_TGT  = 4;
  localparam int B_IRQ_WRAP = 5;
  localparam int B_ALT      = 8;

  function automatic logic is_pause(input logic [2:0] m);
    return m == 3'b001;
  endfunction

  function automatic logic is_edge_clr(input logic [2:0] m);
    return m == 3'b011 || m == 3'b101;
  endfunction

  function automatic logic is_halt(input logic [2:0] m);
    return m == 3'b001 || m == 3'b111;
  endfunction
endpackage

// File: rtl/vsync_timer_gate.sv
module vsync_timer_gate
  import vsync_timer_pkg::*;
#(
  parameter int VARIANT = VAR_LINE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       alt_sel,
  input  logic       tick_base,
  input  logic       tick_alt,
  input  logic       hblank,
  input  logic       vblank,
  output logic       step_en,
  output logic       blank_clr
);
  generate
    if (VARIANT == VAR_PLAIN) begin : g_plain
      logic unused_plain;
      assign unused_plain = ^{clk, rst_n, alt_sel, tick_alt, hblank, vblank};
      assign step_en   = tick_base && !is_halt(mode);
      assign blank_clr = 1'b0;
    end else begin : g_video
      logic blank, blank_q, blank_rise, tick;
      logic unused_video;
      if (VARIANT == VAR_FRAME) begin : g_frm
        assign blank = vblank;
        assign unused_video = hblank;
      end else begin : g_line
        assign blank = hblank;
        assign unused_video = vblank;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blank_q <= 1'b0;
        else        blank_q <= blank;
      end
      assign blank_rise = blank && !blank_q;
      assign tick       = alt_sel ? tick_alt : tick_base;
      assign step_en    = tick && !(is_pause(mode) && blank);
      assign blank_clr  = is_edge_clr(mode) && blank_rise;
    end
  endgenerate
endmodule

// File: rtl/vsync_timer_core.sv
module vsync_timer_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          clear,
  input  logic          step_en,
  input  logic [CW-1:0] target,
  input  logic          tgt_clr,
  output logic [CW-1:0] count,
  output logic          hit_evt,
  output logic          wrap_evt
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] count_q;

  function automatic logic [CW-1:0] next_val(input logic [CW-1:0] cur,
                                             input logic [CW-1:0] tgt,
                                             input logic          clr_on);
    if (clr_on && cur == tgt) return '0;
    return cur + 1'b1;
  endfunction

  assign hit_evt  = step_en && (count_q == target);
  assign wrap_evt = step_en && (count_q == TOP);
  assign count    = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (load_en) count_q <= load_val;
    else if (clear)   count_q <= '0;
    else if (step_en) count_q <= next_val(count_q, target, tgt_clr);
  end
endmodule

// File: rtl/vsync_timer_irq.sv
module vsync_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic hit_evt,
  input  logic wrap_evt,
  input  logic en_hit,
  input  logic en_wrap,
  output logic irq,
  output logic armed
);
  logic fire;

  assign fire = armed && ((hit_evt && en_hit) || (wrap_evt && en_wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      armed <= 1'b1;
    end else begin
      irq <= fire;
      if (rearm)     armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/vsync_timer.sv
module vsync_timer
  import vsync_timer_pkg::*;
#(
  parameter int VARIANT = VAR_LINE,
  parameter int CW      = 16,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          tick_base,
  input  logic          tick_alt,
  input  logic          hblank,
  input  logic          vblank,
  output logic          irq
);
  logic [CW-1:0] ctrl_q, tgt_q, count_w;
  logic cnt_wr, ctrl_wr, tgt_wr;
  logic step_raw, blank_clr, core_step, core_clear;
  logic hit_evt, wrap_evt, armed;

  assign cnt_wr  = bus_wr && (reg_sel_e'(bus_addr) == REG_COUNT);
  assign ctrl_wr = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);
  assign tgt_wr  = bus_wr && (reg_sel_e'(bus_addr) == REG_TARGET);

  generate
    if (DW > CW) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DW-1:CW];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tgt_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[CW-1:0];
      if (tgt_wr)  tgt_q  <= bus_wdata[CW-1:0];
    end
  end

  vsync_timer_gate #(.VARIANT(VARIANT)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (ctrl_q[2:0]),
    .alt_sel   (ctrl_q[B_ALT]),
    .tick_base (tick_base),
    .tick_alt  (tick_alt),
    .hblank    (hblank),
    .vblank    (vblank),
    .step_en   (step_raw),
    .blank_clr (blank_clr)
  );

  assign core_clear = ctrl_wr || (blank_clr && !bus_wr);
  assign core_step  = step_raw && !bus_wr && !blank_clr;

  vsync_timer_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (cnt_wr),
    .load_val (bus_wdata[CW-1:0]),
    .clear    (core_clear),
    .step_en  (core_step),
    .target   (tgt_q),
    .tgt_clr  (ctrl_q[B_TGT_CLR]),
    .count    (count_w),
    .hit_evt  (hit_evt),
    .wrap_evt (wrap_evt)
  );

  vsync_timer_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rearm    (ctrl_wr),
    .hit_evt  (hit_evt),
    .wrap_evt (wrap_evt),
    .en_hit   (ctrl_q[B_IRQ_TGT]),
    .en_wrap  (ctrl_q[B_IRQ_WRAP]),
    .irq      (irq),
    .armed    (armed)
  );

  always_comb begin
    case (reg_sel_e'(rd_addr))
      REG_COUNT:  rd_data = count_w;
      REG_CTRL:   rd_data = ctrl_q;
      REG_TARGET: rd_data = tgt_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/vsync_timer_chk.sv
module vsync_timer_chk #(
  parameter int VARIANT = 0,
  parameter int CW      = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [CW-1:0] wlow,
  input logic [CW-1:0] count,
  input logic [CW-1:0] ctrl,
  input logic [CW-1:0] target,
  input logic          hblank,
  input logic          vblank,
  input logic          armed,
  input logic          irq
);
  logic blank;
  assign blank = (VARIANT == 1) ? vblank : hblank;

  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(ctrl[4]) || $past(ctrl[5])));

  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !armed && !bus_wr) |=> !armed);

  p_ctrl_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> (count == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> (count == $past(wlow)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  p_tgt_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && ctrl[3] && count == target) |=> (count == $past(count) || count == '0));

  p_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT != 2 && !bus_wr && ctrl[2:0] == 3'b001 && blank) |=> $stable(count));

  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT == 2 && !bus_wr && (ctrl[2:0] == 3'b001 || ctrl[2:0] == 3'b111)) |=> $stable(count));
endmodule

bind vsync_timer vsync_timer_chk #(.VARIANT(VARIANT), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wlow     (bus_wdata[CW-1:0]),
  .count    (count_w),
  .ctrl     (ctrl_q),
  .target   (tgt_q),
  .hblank   (hblank),
  .vblank   (vblank),
  .armed    (armed),
  .irq      (irq)
);

// File: tb/vsync_timer_tb.sv
module vsync_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [1:0] rd_addr = 2'd0;
  logic tick_base = 1'b0, tick_alt = 1'b0, hblank = 1'b0, vblank = 1'b0;
  logic [15:0] rd0, rd1, rd2;
  logic irq0, irq1, irq2;

  int checks = 0;
  int errors = 0;
  int tcount = 0;
  int base_mode = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int m_cnt[3], m_ctrl[3], m_tgt[3], m_arm[3], m_irq[3];
  int hb_q = 0, vb_q = 0;

  always #2 clk = ~clk;

  vsync_timer #(.VARIANT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_addr(rd_addr), .rd_data(rd0), .tick_base(tick_base), .tick_alt(tick_alt),
    .hblank(hblank), .vblank(vblank), .irq(irq0));
  vsync_timer #(.VARIANT(1)) u_dut_frame (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_addr(rd_addr), .rd_data(rd1), .tick_base(tick_base), .tick_alt(tick_alt),
    .hblank(hblank), .vblank(vblank), .irq(irq1));
  vsync_timer #(.VARIANT(2)) u_dut_plain (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_addr(rd_addr), .rd_data(rd2), .tick_base(tick_base), .tick_alt(tick_alt),
    .hblank(hblank), .vblank(vblank), .irq(irq2));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rd_of(input int v);
    return (v == 0) ? int'(rd0) : (v == 1) ? int'(rd1) : int'(rd2);
  endfunction

  function automatic int irq_of(input int v);
    return (v == 0) ? int'(irq0) : (v == 1) ? int'(irq1) : int'(irq2);
  endfunction

  // behavioural reference model, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < 3; v++) begin
        m_cnt[v] = 0; m_ctrl[v] = 0; m_tgt[v] = 0; m_arm[v] = 1; m_irq[v] = 0;
      end
      hb_q = 0; vb_q = 0;
    end else begin
      for (int v = 0; v < 3; v++) begin
        int blank, prev, sync, sub, low3, run, clr, tick, hit, ov, ev;
        blank = (v == 1) ? int'(vblank) : int'(hblank);
        prev  = (v == 1) ? vb_q : hb_q;
        m_irq[v] = 0;
        if (bus_wr) begin
          if (bus_addr == 2'd0) m_cnt[v] = bus_wdata & 32'hFFFF;
          if (bus_addr == 2'd1) begin m_ctrl[v] = bus_wdata & 32'hFFFF; m_cnt[v] = 0; m_arm[v] = 1; end
          if (bus_addr == 2'd2) m_tgt[v] = bus_wdata & 32'hFFFF;
        end else begin
          low3 = m_ctrl[v] % 8;
          sync = low3 % 2;
          sub  = low3 / 2;
          run = 1; clr = 0;
          if (v < 2 && sync == 1) begin
            if (sub == 0 && blank == 1) run = 0;
            if ((sub == 1 || sub == 2) && blank == 1 && prev == 0) clr = 1;
          end
          if (v == 2 && (low3 == 1 || low3 == 7)) run = 0;
          tick = (v < 2 && ((m_ctrl[v] / 256) % 2) == 1) ? int'(tick_alt) : int'(tick_base);
          if (clr == 1) m_cnt[v] = 0;
          else if (run == 1 && tick == 1) begin
            hit = (m_cnt[v] == m_tgt[v]) ? 1 : 0;
            ov  = (m_cnt[v] == 65535) ? 1 : 0;
            if (((m_ctrl[v] / 8) % 2) == 1 && hit == 1) m_cnt[v] = 0;
            else m_cnt[v] = (m_cnt[v] + 1) % 65536;
            ev = ((hit == 1 && ((m_ctrl[v] / 16) % 2) == 1) ||
                  (ov == 1 && ((m_ctrl[v] / 32) % 2) == 1)) ? 1 : 0;
            if (ev == 1 && m_arm[v] == 1) begin m_irq[v] = 1; m_arm[v] = 0; end
          end
        end
      end
      hb_q = int'(hblank); vb_q = int'(vblank);
    end
  end

  // stimulus generator for enables and blank strobes
  always @(negedge clk) begin
    tcount++;
    hblank    <= ((tcount % 16) >= 12);
    vblank    <= ((tcount % 64) >= 50);
    tick_alt  <= ((tcount % 3) == 0);
    tick_base <= (base_mode == 0) ? 1'b1 : (base_mode == 1) ? ((tcount % 2) == 0) : ((tcount % 5) != 2);
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      for (int v = 0; v < 3; v++) begin
        if (rd_addr == 2'd0) chk($sformatf("%s count v%0d", cur_req, v), rd_of(v), m_cnt[v]);
        chk($sformatf("%s irq v%0d", cur_req, v), irq_of(v), m_irq[v]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr <= 1'b1; bus_addr <= a; bus_wdata <= d;
    @(negedge clk);
    bus_wr <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input int exp);
    @(negedge clk);
    rd_addr <= a;
    #2;
    for (int v = 0; v < 3; v++) chk($sformatf("%s read v%0d", req, v), rd_of(v), exp);
    @(negedge clk);
    rd_addr <= 2'd0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    for (int v = 0; v < 3; v++) begin
      chk("R1 count", rd_of(v), 0);
      chk("R1 irq", irq_of(v), 0);
    end
    rst_n = 1'b1;
    rd_check("R1 ctrl", 2'd1, 0);
    rd_check("R1 target", 2'd2, 0);

    cur_req = "R2"; base_mode = 0; idle(40);
    base_mode = 1; idle(30);

    cur_req = "R3"; base_mode = 0;
    wr(2'd1, 32'h0000_0020);
    wr(2'd0, 32'h0001_FFF8);
    rd_check("R3 count low bits", 2'd0, 16'hFFF9);
    rd_check("R3 ctrl readback", 2'd1, 16'h0020);
    rd_check("R3 unused address", 2'd3, 0);
    cur_req = "R5"; idle(20);

    cur_req = "R4";
    wr(2'd2, 32'h0000_0005);
    wr(2'd1, 32'hABCD_0018);
    rd_check("R4 target readback", 2'd2, 5);
    cur_req = "R6"; idle(30);
    wr(2'd1, 32'h0000_0018);
    idle(12);
    base_mode = 2; idle(30);

    cur_req = "R5"; base_mode = 0;
    wr(2'd2, 32'h0000_FFFF);
    wr(2'd1, 32'h0000_0030);
    wr(2'd0, 32'h0000_FFFA);
    idle(12);

    cur_req = "R7"; wr(2'd1, 32'h0000_0100); idle(40);

    cur_req = "R8"; base_mode = 0; wr(2'd1, 32'h0000_0001); idle(140);
    cur_req = "R9"; wr(2'd1, 32'h0000_0003); idle(140);
    wr(2'd1, 32'h0000_0005); base_mode = 1; idle(140);
    cur_req = "R10"; base_mode = 0; wr(2'd1, 32'h0000_0007); idle(60);
    cur_req = "R11"; wr(2'd1, 32'h0000_0009); idle(30);

    cur_req = "R12";
    for (int k = 0; k < 20; k++) begin
      wr(2'd0, 32'h0000_0000 + 32'(k * 3));
      wr(2'd1, (k % 2 == 0) ? 32'h0000_0013 : 32'h0000_0001);
    end
    idle(10);

    done = 1'b1;
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule